// File: doc/BRIEF.md
# Transmit Descriptor Ring DMA Engine

This block drains a ring of transmit descriptors kept in system memory and streams the frame bytes that each descriptor points at. Software fills a descriptor, clears its completion flag and then moves a producer index forward. The engine keeps its own consumer index. While the two indices differ and transmission is enabled, the engine reads the descriptor, streams the referenced buffer one byte per beat, optionally marks the descriptor complete in memory and advances its index modulo the ring size.

Descriptors are 16 bytes long and sit at `ring base + 16 * index`. The word at offset 0 holds the buffer address. The word at offset 4 holds the completion flag in bit 31, a last-segment flag in bit 30 and the byte length in bits 29:16. Bits 26:24 of the word at offset 12 give a destination port, which is driven out as sideband next to the byte stream. Stopping is cooperative: when the enable is cleared the engine finishes the descriptor in hand and then drops its busy flag.

Top module: `txdma_ring_engine`

## Requirements
- R1: After reset the ring base, producer index, consumer index and configuration all read 0, and the ring size reads 4. No memory request or stream beat is active.
- R2: Register word addresses are 0 ring base (bits 3:0 read 0), 1 ring size, 2 producer index, 3 consumer index (read-only), 4 configuration (bit 0 enable, bit 1 busy and read-only, bit 6 writeback enable) and 5 index reset (write-only, reads 0). Addresses 6 and 7 read 0.
- R3: The engine makes no memory request while it is idle and either disabled or the two indices are equal. Once enabled with unequal indices, its first request reads the descriptor at ring base + 16 * consumer index.
- R4: The engine streams exactly as many bytes as the length field holds. It reads the buffer in 32-bit words from the word-aligned buffer address and sends the lowest byte of each word first. st_last is high only on the final byte, and a length of zero sends no byte.
- R5: st_port carries bits 26:24 of the descriptor word at offset 12 on every byte of that descriptor.
- R6: With writeback enabled, the engine makes exactly one write per descriptor, to offset 4. That write carries the fetched word with bit 31 set and all other bits unchanged. With writeback disabled it writes nothing.
- R7: After each descriptor the consumer index moves up by one, and it returns to 0 when it reaches the ring size.
- R8: If the enable is cleared while a descriptor is in flight, that descriptor still finishes and the consumer index moves once. Busy then reads 0 and no further memory request is made.
- R9: Writing 1 to bit 0 at the index-reset address sets the consumer index to 0 and leaves the producer index alone.
- R10: While st_valid is high and st_ready is low, st_valid, st_data and st_last hold their values.
- R11: Once raised, a memory request holds its address, direction and write data until mem_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge; read data valid with it |
| mem_rdata | input | 32 | Memory read data |
| st_valid | output | 1 | Stream byte valid |
| st_ready | input | 1 | Stream byte accepted |
| st_data | output | 8 | Stream byte |
| st_last | output | 1 | Final byte of a frame |
| st_port | output | 3 | Destination port sideband |

## Verification
The hardest case to reach is clearing the enable while a descriptor is still in flight. The window between the first fetch and the writeback is only a few cycles when the stream sink is always ready. The stimulus therefore queues two descriptors while the engine is disabled and turns on backpressure on the stream to stretch the first transfer. It enables the engine, waits for the first byte to appear and then clears the enable. The first descriptor must complete and the second must never be fetched. Index wrap is reached by running more descriptors than the ring holds, with lengths that cover partial final words and zero.

// File: rtl/txd_pkg.sv
package txd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_W_BUF,
    ST_W_CTL,
    ST_W_PORT,
    ST_DATA,
    ST_DRAIN,
    ST_WBACK
  } txd_state_e;

  // register word addresses
  localparam logic [2:0] RA_BASE = 3'd0;
  localparam logic [2:0] RA_SIZE = 3'd1;
  localparam logic [2:0] RA_PROD = 3'd2;
  localparam logic [2:0] RA_CONS = 3'd3;
  localparam logic [2:0] RA_CFG  = 3'd4;
  localparam logic [2:0] RA_IRST = 3'd5;

  // configuration bits
  localparam int CFG_EN   = 0;
  localparam int CFG_BUSY = 1;
  localparam int CFG_WB   = 6;

  // descriptor layout
  localparam int LEN_W     = 14;
  localparam int LEN_LSB   = 16;
  localparam int DONE_BIT  = 31;
  localparam int PORT_LSB  = 24;
  localparam int PORT_W    = 3;
  localparam logic [31:0] OFS_BUF  = 32'd0;
  localparam logic [31:0] OFS_CTL  = 32'd4;
  localparam logic [31:0] OFS_PORT = 32'd12;

endpackage

// File: rtl/txd_regs.sv
module txd_regs
  import txd_pkg::*;
#(
  parameter int IDX_W    = 8,
  parameter int RING_DEF = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [2:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             busy,
  input  logic             adv,
  output logic [31:0]      ring_base,
  output logic [IDX_W-1:0] prod_idx,
  output logic [IDX_W-1:0] cons_idx,
  output logic             tx_en,
  output logic             wb_en
);

  localparam int SIZE_W = IDX_W + 1;

  logic [31:4]       base_q, base_d;
  logic [SIZE_W-1:0] size_q, size_d;
  logic [IDX_W-1:0]  prod_q, prod_d;
  logic [IDX_W-1:0]  cons_q, cons_d;
  logic              en_q, en_d;
  logic              wb_q, wb_d;
  logic [SIZE_W-1:0] cons_plus;
  logic [IDX_W-1:0]  cons_next;
  logic              irst_hit;

  always_comb begin
    cons_plus = SIZE_W'(cons_q) + SIZE_W'(1);
    cons_next = (cons_plus == size_q) ? '0 : cons_plus[IDX_W-1:0];
    irst_hit  = reg_we && (reg_addr == RA_IRST) && reg_wdata[0];
  end

  // next-state logic
  always_comb begin
    base_d = base_q;
    size_d = size_q;
    prod_d = prod_q;
    en_d   = en_q;
    wb_d   = wb_q;
    if (reg_we) begin
      case (reg_addr)
        RA_BASE: base_d = reg_wdata[31:4];
        RA_SIZE: size_d = reg_wdata[SIZE_W-1:0];
        RA_PROD: prod_d = reg_wdata[IDX_W-1:0];
        RA_CFG: begin
          en_d = reg_wdata[CFG_EN];
          wb_d = reg_wdata[CFG_WB];
        end
        default: ;
      endcase
    end
    if (irst_hit) begin
      cons_d = '0;
    end else if (adv) begin
      cons_d = cons_next;
    end else begin
      cons_d = cons_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      size_q <= SIZE_W'(RING_DEF);
      prod_q <= '0;
      cons_q <= '0;
      en_q   <= 1'b0;
      wb_q   <= 1'b0;
    end else begin
      base_q <= base_d;
      size_q <= size_d;
      prod_q <= prod_d;
      cons_q <= cons_d;
      en_q   <= en_d;
      wb_q   <= wb_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_BASE: reg_rdata = {base_q, 4'b0000};
      RA_SIZE: reg_rdata = 32'(size_q);
      RA_PROD: reg_rdata = 32'(prod_q);
      RA_CONS: reg_rdata = 32'(cons_q);
      RA_CFG: begin
        reg_rdata[CFG_EN]   = en_q;
        reg_rdata[CFG_BUSY] = busy;
        reg_rdata[CFG_WB]   = wb_q;
      end
      default: reg_rdata = '0;
    endcase
  end

  assign ring_base = {base_q, 4'b0000};
  assign prod_idx  = prod_q;
  assign cons_idx  = cons_q;
  assign tx_en     = en_q;
  assign wb_en     = wb_q;

  // R7: completing the last slot of the ring returns the consumer index to zero
  p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !irst_hit && (cons_plus == size_q)) |=> (cons_idx == '0));

  // R9: index reset clears the consumer index, producer index untouched
  p_irst_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irst_hit && !(reg_we && reg_addr == RA_PROD)) |=> (cons_idx == '0) && $stable(prod_idx));

endmodule

// File: rtl/txd_unpack.sv
module txd_unpack (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [31:0] word,
  input  logic [2:0]  nbytes,
  input  logic        last_word,
  output logic        empty,
  output logic        st_valid,
  input  logic        st_ready,
  output logic [7:0]  st_data,
  output logic        st_last
);

  logic [31:0] word_q, word_d;
  logic [2:0]  cnt_q, cnt_d;
  logic        last_q, last_d;
  logic        beat;

  assign beat = (cnt_q != 3'd0) && st_ready;

  always_comb begin
    word_d = word_q;
    cnt_d  = cnt_q;
    last_d = last_q;
    if (load) begin
      word_d = word;
      cnt_d  = nbytes;
      last_d = last_word;
    end else if (beat) begin
      word_d = {8'h00, word_q[31:8]};
      cnt_d  = cnt_q - 3'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      cnt_q  <= '0;
      last_q <= 1'b0;
    end else begin
      word_q <= word_d;
      cnt_q  <= cnt_d;
      last_q <= last_d;
    end
  end

  assign empty    = (cnt_q == 3'd0);
  assign st_valid = !empty;
  assign st_data  = word_q[7:0];
  assign st_last  = last_q && (cnt_q == 3'd1);

  // R10: a stalled beat keeps its value
  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_ready) |=> st_valid && $stable(st_data) && $stable(st_last));

  // R4: the sequencer only loads a word once the previous one is drained
  p_load_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> empty);

endmodule

// File: rtl/txd_ctrl.sv
module txd_ctrl
  import txd_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              wb_en,
  input  logic [31:0]       ring_base,
  input  logic [IDX_W-1:0]  prod_idx,
  input  logic [IDX_W-1:0]  cons_idx,
  output logic              adv,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  input  logic              up_empty,
  output logic              up_load,
  output logic [31:0]       up_word,
  output logic [2:0]        up_nbytes,
  output logic              up_last,
  output logic [PORT_W-1:0] port
);

  txd_state_e        state_q, state_d;
  logic [31:0]       buf_q, buf_d;
  logic [31:0]       ctl_q, ctl_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic [PORT_W-1:0] port_q, port_d;
  logic [IDX_W-1:0]  cur_q, cur_d;
  logic [31:0]       desc_addr;
  logic [2:0]        chunk;
  logic              chunk_last;

  assign desc_addr  = ring_base + (32'(cur_q) << 4);
  assign chunk      = (rem_q >= LEN_W'(4)) ? 3'd4 : rem_q[2:0];
  assign chunk_last = (rem_q <= LEN_W'(4));

  always_comb begin
    state_d   = state_q;
    buf_d     = buf_q;
    ctl_d     = ctl_q;
    rem_d     = rem_q;
    port_d    = port_q;
    cur_d     = cur_q;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    up_load   = 1'b0;
    up_nbytes = 3'd0;
    up_last   = 1'b0;
    adv       = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (tx_en && (cons_idx != prod_idx)) begin
          cur_d   = cons_idx;
          state_d = ST_W_BUF;
        end
      end
      ST_W_BUF: begin
        mem_req  = 1'b1;
        mem_addr = desc_addr + OFS_BUF;
        if (mem_ack) begin
          buf_d   = {mem_rdata[31:2], 2'b00};
          state_d = ST_W_CTL;
        end
      end
      ST_W_CTL: begin
        mem_req  = 1'b1;
        mem_addr = desc_addr + OFS_CTL;
        if (mem_ack) begin
          ctl_d   = mem_rdata;
          rem_d   = mem_rdata[LEN_LSB +: LEN_W];
          state_d = ST_W_PORT;
        end
      end
      ST_W_PORT: begin
        mem_req  = 1'b1;
        mem_addr = desc_addr + OFS_PORT;
        if (mem_ack) begin
          port_d  = mem_rdata[PORT_LSB +: PORT_W];
          state_d = (rem_q == '0) ? ST_WBACK : ST_DATA;
        end
      end
      ST_DATA: begin
        if (up_empty) begin
          mem_req  = 1'b1;
          mem_addr = buf_q;
          if (mem_ack) begin
            up_load   = 1'b1;
            up_nbytes = chunk;
            up_last   = chunk_last;
            rem_d     = rem_q - LEN_W'(chunk);
            buf_d     = buf_q + 32'd4;
            if (chunk_last) state_d = ST_DRAIN;
          end
        end
      end
      ST_DRAIN: begin
        if (up_empty) state_d = ST_WBACK;
      end
      ST_WBACK: begin
        if (wb_en) begin
          mem_req   = 1'b1;
          mem_we    = 1'b1;
          mem_addr  = desc_addr + OFS_CTL;
          mem_wdata = ctl_q;
          mem_wdata[DONE_BIT] = 1'b1;
          if (mem_ack) begin
            adv     = 1'b1;
            state_d = ST_IDLE;
          end
        end else begin
          adv     = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      buf_q   <= '0;
      ctl_q   <= '0;
      rem_q   <= '0;
      port_q  <= '0;
      cur_q   <= '0;
    end else begin
      state_q <= state_d;
      buf_q   <= buf_d;
      ctl_q   <= ctl_d;
      rem_q   <= rem_d;
      port_q  <= port_d;
      cur_q   <= cur_d;
    end
  end

  assign up_word = mem_rdata;
  assign busy    = (state_q != ST_IDLE);
  assign port    = port_q;

  // R11: an outstanding request is held unchanged until acknowledged
  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R3: no fetch starts while idle and disabled or caught up
  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (!tx_en || cons_idx == prod_idx)) |=> !mem_req);

  // R6: memory writes only happen when writeback is enabled
  p_wb_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> wb_en);

endmodule

// File: rtl/txdma_ring_engine.sv
module txdma_ring_engine
  import txd_pkg::*;
#(
  parameter int IDX_W    = 8,
  parameter int RING_DEF = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        st_valid,
  input  logic        st_ready,
  output logic [7:0]  st_data,
  output logic        st_last,
  output logic [2:0]  st_port
);

  logic [1:0]        rst_sync_q;
  logic              rst_n_int;
  logic              busy, adv, tx_en, wb_en;
  logic [31:0]       ring_base;
  logic [IDX_W-1:0]  prod_idx, cons_idx;
  logic              up_empty, up_load, up_last;
  logic [31:0]       up_word;
  logic [2:0]        up_nbytes;
  logic [PORT_W-1:0] port;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  txd_regs #(.IDX_W(IDX_W), .RING_DEF(RING_DEF)) i_regs (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .busy      (busy),
    .adv       (adv),
    .ring_base (ring_base),
    .prod_idx  (prod_idx),
    .cons_idx  (cons_idx),
    .tx_en     (tx_en),
    .wb_en     (wb_en)
  );

  txd_ctrl #(.IDX_W(IDX_W)) i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .tx_en     (tx_en),
    .wb_en     (wb_en),
    .ring_base (ring_base),
    .prod_idx  (prod_idx),
    .cons_idx  (cons_idx),
    .adv       (adv),
    .busy      (busy),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .up_empty  (up_empty),
    .up_load   (up_load),
    .up_word   (up_word),
    .up_nbytes (up_nbytes),
    .up_last   (up_last),
    .port      (port)
  );

  txd_unpack i_unpack (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .load      (up_load),
    .word      (up_word),
    .nbytes    (up_nbytes),
    .last_word (up_last),
    .empty     (up_empty),
    .st_valid  (st_valid),
    .st_ready  (st_ready),
    .st_data   (st_data),
    .st_last   (st_last)
  );

  assign st_port = port;

  // R5: sideband is steady across a stalled beat
  p_port_hold_r5: assert property (@(posedge clk) disable iff (!rst_n_int)
    (st_valid && !st_ready) |=> $stable(st_port));

endmodule

// File: tb/test_txdma_ring_engine.sv
module test_txdma_ring_engine;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {length[13:0], port[2:0], writeback}
  localparam logic [17:0] VEC [NVEC] = '{
    {14'd1,  3'd2, 1'b1},
    {14'd4,  3'd5, 1'b1},
    {14'd5,  3'd0, 1'b0},
    {14'd7,  3'd7, 1'b1},
    {14'd0,  3'd3, 1'b1},
    {14'd13, 3'd1, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        st_valid, st_ready, st_last;
  logic [7:0]  st_data;
  logic [2:0]  st_port;
  logic        bp_on = 1'b0;
  logic [31:0] cyc = '0;
  logic [31:0] mem [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  txdma_ring_engine i_txdma_ring_engine (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .st_valid(st_valid),
    .st_ready(st_ready), .st_data(st_data), .st_last(st_last), .st_port(st_port)
  );

  // memory model: acknowledge one cycle after a request
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_req && !mem_ack) begin
      mem_ack   <= 1'b1;
      mem_rdata <= mem[mem_addr[9:2]];
    end else begin
      mem_ack <= 1'b0;
    end
  end

  assign st_ready = !bp_on || cyc[0];

  // monitors, sampled mid-cycle
  int          cap_n = 0, wb_n = 0, ack_n = 0, hold_err = 0, req_err = 0;
  logic [7:0]  cap_data [256];
  logic        cap_last [256];
  logic [2:0]  cap_port [256];
  logic [31:0] wb_addr [256];
  logic [31:0] wb_data [256];
  logic [31:0] ack_addr [256];
  logic        pv = 1'b0, pr = 1'b0, pl = 1'b0;
  logic [7:0]  pd = '0;
  logic [31:0] pa = '0;

  always @(negedge clk) begin
    if (st_valid && st_ready) begin
      cap_data[cap_n % 256] = st_data;
      cap_last[cap_n % 256] = st_last;
      cap_port[cap_n % 256] = st_port;
      cap_n = cap_n + 1;
    end
    if (mem_req && mem_ack) begin
      ack_addr[ack_n % 256] = mem_addr;
      ack_n = ack_n + 1;
      if (mem_we) begin
        wb_addr[wb_n % 256] = mem_addr;
        wb_data[wb_n % 256] = mem_wdata;
        wb_n = wb_n + 1;
      end
    end
    if (pv && (!st_valid || st_data != pd || st_last != pl)) hold_err = hold_err + 1;
    pv = st_valid && !st_ready; pd = st_data; pl = st_last;
    if (pr && (!mem_req || mem_addr != pa)) req_err = req_err + 1;
    pr = mem_req && !mem_ack; pa = mem_addr;
  end

  int n_chk = 0, n_err = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [7:0] pat(input int v, input int k);
    return 8'(8'hA0 + v * 16 + k * 3);
  endfunction

  task automatic put_desc(input int idx, input int v, input logic [31:0] bufa,
                          input logic [13:0] len, input logic [2:0] port, input logic [15:0] tag);
    mem[idx*4 + 0] = bufa;
    mem[idx*4 + 1] = {1'b0, 1'b1, len, tag};
    mem[idx*4 + 2] = 32'hDEAD0000;
    mem[idx*4 + 3] = {5'b10101, port, 24'h3C3C3C};
    for (int w = 0; w < 4; w++)
      mem[bufa[9:2] + w] = {pat(v, 4*w+3), pat(v, 4*w+2), pat(v, 4*w+1), pat(v, 4*w)};
  endtask

  task automatic wait_done(input logic [31:0] exp_idx, output bit ok);
    logic [31:0] d, c;
    ok = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      reg_read(3'd3, d);
      reg_read(3'd4, c);
      if (d == exp_idx && !c[1]) begin ok = 1'b1; break; end
    end
  endtask

  task automatic run_tests();
    logic [31:0] d;
    bit ok;
    int s_cap, s_wb, s_ack, bad, lbad, pbad;
    // R1: reset state
    reg_read(3'd0, d); chk("R1 base", d, 32'h0);
    reg_read(3'd1, d); chk("R1 ring size", d, 32'd4);
    reg_read(3'd2, d); chk("R1 producer", d, 32'h0);
    reg_read(3'd3, d); chk("R1 consumer", d, 32'h0);
    reg_read(3'd4, d); chk("R1 config", d, 32'h0);
    chk("R1 no request", {31'd0, mem_req}, 32'h0);
    chk("R1 no stream", {31'd0, st_valid}, 32'h0);
    // R2: register map
    reg_write(3'd0, 32'h12345678); reg_read(3'd0, d); chk("R2 base low bits", d, 32'h12345670);
    reg_write(3'd2, 32'd5); reg_read(3'd2, d); chk("R2 producer", d, 32'd5);
    reg_write(3'd4, 32'h0000FF40); reg_read(3'd4, d); chk("R2 config", d, 32'h40);
    reg_read(3'd6, d); chk("R2 unmapped", d, 32'h0);
    reg_read(3'd5, d); chk("R2 index reset reads 0", d, 32'h0);
    reg_write(3'd2, 32'd0); reg_write(3'd0, 32'd0);

    // table of descriptors, walked around the ring
    for (int v = 0; v < NVEC; v++) begin
      int idx;
      logic [13:0] len;
      logic [2:0] port;
      logic [31:0] bufa;
      idx  = v % 4;
      len  = VEC[v][17:4];
      port = VEC[v][3:1];
      bufa = 32'h100 + 32'(v) * 32'h40;
      put_desc(idx, v, bufa, len, port, 16'h5A00 + 16'(v));
      s_cap = cap_n; s_wb = wb_n;
      bp_on = v[0];
      reg_write(3'd4, {25'd0, VEC[v][0], 6'd1});
      reg_write(3'd2, 32'((idx + 1) % 4));
      wait_done(32'((idx + 1) % 4), ok);
      chk("R7 consumer index advanced/wrapped", {31'd0, ok}, 32'd1);
      chk("R4 byte count", 32'(cap_n - s_cap), 32'(len));
      bad = 0; lbad = 0; pbad = 0;
      for (int k = 0; k < int'(len); k++) begin
        if (cap_data[(s_cap + k) % 256] !== pat(v, k)) bad++;
        if (cap_last[(s_cap + k) % 256] !== (k == int'(len) - 1)) lbad++;
        if (cap_port[(s_cap + k) % 256] !== port) pbad++;
      end
      chk("R4 byte values", 32'(bad), 32'd0);
      chk("R4 last marker", 32'(lbad), 32'd0);
      chk("R5 port sideband", 32'(pbad), 32'd0);
      if (VEC[v][0]) begin
        chk("R6 one writeback", 32'(wb_n - s_wb), 32'd1);
        chk("R6 writeback address", wb_addr[s_wb % 256], 32'(idx * 16 + 4));
        chk("R6 writeback data", wb_data[s_wb % 256], {1'b1, 1'b1, len, 16'h5A00 + 16'(v)});
      end else begin
        chk("R6 no writeback", 32'(wb_n - s_wb), 32'd0);
      end
    end

    // R3 and R8: disabled engine, then stop mid-descriptor
    put_desc(2, 6, 32'h300, 14'd9, 3'd4, 16'h0077);
    put_desc(3, 7, 32'h340, 14'd6, 3'd6, 16'h0078);
    reg_write(3'd4, 32'h40);
    s_ack = ack_n;
    reg_write(3'd2, 32'd0);
    repeat (20) @(negedge clk);
    chk("R3 no fetch while disabled", 32'(ack_n - s_ack), 32'd0);
    reg_read(3'd3, d); chk("R3 consumer unchanged while disabled", d, 32'd2);
    bp_on = 1'b1;
    s_cap = cap_n;
    reg_write(3'd4, 32'h41);
    for (int i = 0; i < 500 && cap_n == s_cap; i++) @(negedge clk);
    chk("R3 first fetch address", ack_addr[s_ack % 256], 32'h20);
    reg_write(3'd4, 32'h40);
    for (int i = 0; i < 500; i++) begin
      reg_read(3'd4, d);
      if (!d[1]) break;
    end
    chk("R8 busy drops", d & 32'h2, 32'h0);
    reg_read(3'd3, d); chk("R8 consumer moved once", d, 32'd3);
    chk("R8 descriptor completed", 32'(cap_n - s_cap), 32'd9);
    s_ack = ack_n;
    repeat (30) @(negedge clk);
    chk("R8 no fetch after stop", 32'(ack_n - s_ack), 32'd0);
    reg_write(3'd4, 32'h41);
    wait_done(32'd0, ok);
    chk("R3 resumes after enable", {31'd0, ok}, 32'd1);
    chk("R3 both descriptors streamed", 32'(cap_n - s_cap), 32'd15);

    // R9: index reset
    bp_on = 1'b0;
    put_desc(0, 8, 32'h380, 14'd2, 3'd1, 16'h0079);
    reg_write(3'd2, 32'd1);
    wait_done(32'd1, ok);
    reg_write(3'd4, 32'h0);
    reg_write(3'd5, 32'h1);
    reg_read(3'd3, d); chk("R9 consumer cleared", d, 32'd0);
    reg_read(3'd2, d); chk("R9 producer kept", d, 32'd1);
    reg_write(3'd2, 32'd0);

    chk("R10 stalled beats held", 32'(hold_err), 32'd0);
    chk("R11 requests held until ack", 32'(req_err), 32'd0);
  endtask

  initial begin
    bit wd = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    fork
      run_tests();
      begin repeat (150000) @(posedge clk); wd = 1'b1; end
    join_any
    disable fork;
    if (wd) chk("watchdog", 32'd1, 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule